// File: doc/BRIEF.md
# Dual-Port USB PHY Bring-Up Sequencer

This block brings two USB physical-layer ports out of reset without software stepping through each write. Both ports share one 32-bit configuration register and each has its own 32-bit misc register. A one-cycle start pulse makes the sequencer take a snapshot of the configuration register and program the clock: crystal source, divider and clock enable. It then pulses four reset groups in a fixed order, with both ports driven in the same write, and waits a fixed dwell after every write of the chain. At the end it checks the two clock-detected status bits and raises a warning if either is missing.

After the clock check, the sequencer updates each port's misc register with a read-modify-write that installs the ID-override mode, then pulses done. A stop request puts both ports back into power-on reset with a single write that keeps every other configuration bit. A stop can arrive while idle or in the middle of a bring-up, and it aborts a bring-up.

The register file sits outside the block. The sequencer sees current register contents on read-data inputs and issues one-cycle write strobes with full-word write data. The dwell is a parameter counted in clock cycles. Its default is 200 µs at the stated clock frequency.

Top module: `usbphy_bringup_seq`

## Requirements
- R1: While reset is applied, and once it has been released with no request, busy, done, warning and all three write strobes are low.
- R2: On a start pulse while idle, the first configuration write is the captured read value with the following changes. Bits 30:24 hold (CLK_DIV_RATIO-1). Bits 7:5 are 0, which selects the crystal. Bit 8 (clock enable) is 1. Reset bits 19,18,17,13,12,11 and POR bits 1,0 are 0. All other bits are kept.
- R3: Eight more configuration writes follow the first, each built from that first word. The odd-numbered writes add, in this order, the controller resets (bits 17 and 11), the PLL resets (bits 19 and 13), the PHY resets (bits 18 and 12) and the POR bits (0 and 1). Each even-numbered write restores the plain first word. Port A and port B bits always change together.
- R4: The second write comes in the clock cycle right after the first. Every later write of the chain is followed by exactly DWELL_CYC cycles with no write strobe, so successive write strobes from the second onward are DWELL_CYC+1 cycles apart.
- R5: One cycle after the final dwell, the block samples configuration read bits 31 (port A) and 22 (port B). The warning output goes high if either bit is 0 and low if both are 1. It holds that value until the next accepted start clears it.
- R6: Each port's misc write data is the misc read value with bits 23:22 replaced and all other bits kept. The port mode is latched at start: mode 2'b10 writes 2'b10 (host override), mode 2'b11 writes 2'b11 (device override), and 2'b00 or 2'b01 writes 2'b00 (no override). Both misc writes happen in the same cycle, two cycles after the final dwell ends.
- R7: Busy is high from the cycle after an accepted start until done. Done is a single-cycle pulse in the cycle after the misc writes, and busy is low in the following cycle.
- R8: A start pulse while busy has no effect: the sequence keeps its nine writes, one done pulse and timing, and no further write follows it.
- R9: A stop pulse, whether idle or busy, aborts any sequence. In the next cycle it issues exactly one configuration write equal to the current read value with bits 1 and 0 set, and the block then returns to idle with no done pulse. A stop wins over a start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to run the bring-up sequence |
| stop_i | input | 1 | One-cycle request to put both ports into power-on reset |
| mode_a_i | input | 2 | Port A mode: 2'b10 host override, 2'b11 device override, else none |
| mode_b_i | input | 2 | Port B mode, same encoding |
| cfg_rd_i | input | 32 | Current configuration register value, including status bits 31 and 22 |
| misc_a_rd_i | input | 32 | Current port A misc register value |
| misc_b_rd_i | input | 32 | Current port B misc register value |
| cfg_wr_o | output | 1 | Configuration register write strobe |
| cfg_wdata_o | output | 32 | Configuration register write data |
| misc_a_wr_o | output | 1 | Port A misc write strobe |
| misc_a_wdata_o | output | 32 | Port A misc write data |
| misc_b_wr_o | output | 1 | Port B misc write strobe |
| misc_b_wdata_o | output | 32 | Port B misc write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence completes |
| clk_warn_o | output | 1 | A clock-detected bit was missing at the end of the last sequence |

## Verification
The bench builds the block with DWELL_CYC = 4 and CLK_DIV_RATIO = 2. A short dwell makes every dwell gap, the full write order and several complete bring-ups fit in a few hundred cycles, so strobe spacing can be checked cycle-exactly against DWELL_CYC+1. The default divider ratio puts the divider field at 1, which checks the minus-one encoding. The vectors vary register contents and status bits, so both kept-bit paths and every warning outcome are reached. Starting and stopping in the middle of a dwell exercises the abort and ignore paths at a known step.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

  localparam int CFG_W      = 32;

  // Configuration word: status, clocking and reset fields
  localparam int B_DET_A    = 31;
  localparam int B_DET_B    = 22;
  localparam int DIV_LO     = 24;
  localparam int DIV_W      = 7;
  localparam int SEL_LO     = 5;
  localparam int SEL_W      = 3;
  localparam int B_CLK_EN   = 8;
  localparam int B_PLL_A    = 19;
  localparam int B_PHY_A    = 18;
  localparam int B_CTL_A    = 17;
  localparam int B_PLL_B    = 13;
  localparam int B_PHY_B    = 12;
  localparam int B_CTL_B    = 11;
  localparam int B_POR_B    = 1;
  localparam int B_POR_A    = 0;

  // Misc word: ID override field
  localparam int B_OVR_EN   = 23;
  localparam int B_OVR_DEV  = 22;

  localparam logic [SEL_W-1:0] SEL_XTAL = '0;

  localparam int STEP_W     = 4;
  localparam int LAST_STEP  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_DWELL,
    ST_CHECK,
    ST_MODE,
    ST_DONE,
    ST_STOP
  } seq_state_e;

  // Pulse groups in the order they are exercised
  typedef enum logic [1:0] {
    GRP_CTL = 2'd0,
    GRP_PLL = 2'd1,
    GRP_PHY = 2'd2,
    GRP_POR = 2'd3
  } rst_grp_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'b00,
    PM_RSVD = 2'b01,
    PM_HOST = 2'b10,
    PM_DEV  = 2'b11
  } port_mode_e;

  function automatic logic [CFG_W-1:0] bit_at(input int pos);
    return CFG_W'(1) << pos;
  endfunction

  function automatic logic [CFG_W-1:0] grp_mask(input rst_grp_e g);
    logic [CFG_W-1:0] m;
    case (g)
      GRP_CTL: m = bit_at(B_CTL_A) | bit_at(B_CTL_B);
      GRP_PLL: m = bit_at(B_PLL_A) | bit_at(B_PLL_B);
      GRP_PHY: m = bit_at(B_PHY_A) | bit_at(B_PHY_B);
      default: m = bit_at(B_POR_A) | bit_at(B_POR_B);
    endcase
    return m;
  endfunction

  localparam logic [CFG_W-1:0] POR_MASK   = (CFG_W'(1) << B_POR_A) | (CFG_W'(1) << B_POR_B);
  localparam logic [CFG_W-1:0] DIV_MASK   = CFG_W'((1 << DIV_W) - 1) << DIV_LO;
  localparam logic [CFG_W-1:0] SEL_MASK   = CFG_W'((1 << SEL_W) - 1) << SEL_LO;
  localparam logic [CFG_W-1:0] RST_A_MASK = (CFG_W'(1) << B_PLL_A) | (CFG_W'(1) << B_PHY_A) |
                                            (CFG_W'(1) << B_CTL_A);
  localparam logic [CFG_W-1:0] RST_B_MASK = (CFG_W'(1) << B_PLL_B) | (CFG_W'(1) << B_PHY_B) |
                                            (CFG_W'(1) << B_CTL_B);
  localparam logic [CFG_W-1:0] CFG_CLR_MASK = DIV_MASK | SEL_MASK | RST_A_MASK | RST_B_MASK | POR_MASK;
  localparam logic [CFG_W-1:0] OVR_MASK   = (CFG_W'(1) << B_OVR_EN) | (CFG_W'(1) << B_OVR_DEV);

endpackage

// File: rtl/usbphy_dwell_timer.sv
module usbphy_dwell_timer #(
  parameter int DWELL_CYC = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clear_i,
  output logic expire_o
);

  localparam int CNT_W = $clog2(DWELL_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DWELL_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || clear_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (clear_i)           cnt_d = '0;
    else if (load_i)       cnt_d = LOAD_VAL;
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == CNT_W'(1));

  // R4: the window shrinks by one every cycle it is not reloaded or cleared
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load_i && !clear_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R9: a clear empties the window on the next cycle
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/usbphy_cfg_compose.sv
module usbphy_cfg_compose
  import usbphy_seq_pkg::*;
#(
  parameter int CLK_DIV_RATIO = 2
) (
  input  logic [CFG_W-1:0]  rd_i,
  input  logic [CFG_W-1:0]  base_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [CFG_W-1:0]  base_o,
  output logic [CFG_W-1:0]  word_o
);

  localparam logic [DIV_W-1:0] DIV_FIELD = DIV_W'(CLK_DIV_RATIO - 1);
  localparam logic [CFG_W-1:0] CLK_SET   = (CFG_W'(DIV_FIELD) << DIV_LO) |
                                           (CFG_W'(SEL_XTAL) << SEL_LO) |
                                           (CFG_W'(1) << B_CLK_EN);

  rst_grp_e grp;

  always_comb begin
    base_o = (rd_i & ~CFG_CLR_MASK) | CLK_SET;
  end

  // Odd steps raise one pulse group, even steps return to the base word
  always_comb begin
    grp = rst_grp_e'(step_i[2:1]);
    if (step_i[0]) word_o = base_i | grp_mask(grp);
    else           word_o = base_i;
  end

endmodule

// File: rtl/usbphy_misc_port.sv
module usbphy_misc_port
  import usbphy_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [1:0]       mode_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] rd_i,
  output logic             wr_o,
  output logic [CFG_W-1:0] wdata_o
);

  port_mode_e       mode_q;
  logic [1:0]       ovr;
  logic [CFG_W-1:0] ovr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= PM_NONE;
    else if (load_i) mode_q <= port_mode_e'(mode_i);
  end

  always_comb begin
    case (mode_q)
      PM_HOST: ovr = 2'b10;
      PM_DEV:  ovr = 2'b11;
      default: ovr = 2'b00;
    endcase
    ovr_bits = (CFG_W'(ovr[1]) << B_OVR_EN) | (CFG_W'(ovr[0]) << B_OVR_DEV);
    wdata_o  = (rd_i & ~OVR_MASK) | ovr_bits;
    wr_o     = wr_en_i;
  end

  // R6: device selection never appears without the override enable
  p_dev_needs_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> !(wdata_o[B_OVR_DEV] && !wdata_o[B_OVR_EN]));

  // R6: bits outside the override field pass through unchanged
  p_rmw_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (((wdata_o ^ rd_i) & ~OVR_MASK) == '0));

endmodule

// File: rtl/usbphy_bringup_seq.sv
module usbphy_bringup_seq
  import usbphy_seq_pkg::*;
#(
  parameter int CLK_HZ        = 200_000_000,
  parameter int DWELL_US      = 200,
  parameter int DWELL_CYC     = (CLK_HZ / 1_000_000) * DWELL_US,
  parameter int CLK_DIV_RATIO = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic [1:0]  mode_a_i,
  input  logic [1:0]  mode_b_i,
  input  logic [31:0] cfg_rd_i,
  input  logic [31:0] misc_a_rd_i,
  input  logic [31:0] misc_b_rd_i,
  output logic        cfg_wr_o,
  output logic [31:0] cfg_wdata_o,
  output logic        misc_a_wr_o,
  output logic [31:0] misc_a_wdata_o,
  output logic        misc_b_wr_o,
  output logic [31:0] misc_b_wdata_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        clk_warn_o
);

  localparam int NPORT = 2;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // Sequencer state
  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CFG_W-1:0]  base_q, base_d;
  logic              warn_q, warn_d;
  logic              base_en;

  logic              tmr_load, tmr_clear, tmr_expire;
  logic              mode_load, misc_wr;
  logic [CFG_W-1:0]  base_from_rd, step_word;

  usbphy_dwell_timer #(
    .DWELL_CYC (DWELL_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (tmr_load),
    .clear_i  (tmr_clear),
    .expire_o (tmr_expire)
  );

  usbphy_cfg_compose #(
    .CLK_DIV_RATIO (CLK_DIV_RATIO)
  ) u_compose (
    .rd_i   (cfg_rd_i),
    .base_i (base_q),
    .step_i (step_q),
    .base_o (base_from_rd),
    .word_o (step_word)
  );

  // Per-port misc read-modify-write units
  logic [1:0]       port_mode [NPORT];
  logic [CFG_W-1:0] port_rd   [NPORT];
  logic [CFG_W-1:0] port_wd   [NPORT];
  logic             port_wr   [NPORT];

  assign port_mode[0] = mode_a_i;
  assign port_mode[1] = mode_b_i;
  assign port_rd[0]   = misc_a_rd_i;
  assign port_rd[1]   = misc_b_rd_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    usbphy_misc_port u_port (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .load_i  (mode_load),
      .mode_i  (port_mode[p]),
      .wr_en_i (misc_wr),
      .rd_i    (port_rd[p]),
      .wr_o    (port_wr[p]),
      .wdata_o (port_wd[p])
    );
  end

  assign misc_a_wr_o    = port_wr[0];
  assign misc_a_wdata_o = port_wd[0];
  assign misc_b_wr_o    = port_wr[1];
  assign misc_b_wdata_o = port_wd[1];

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    base_d    = base_q;
    base_en   = 1'b0;
    warn_d    = warn_q;
    tmr_load  = 1'b0;
    tmr_clear = 1'b0;
    mode_load = 1'b0;
    misc_wr   = 1'b0;

    if (stop_i && state_q != ST_STOP) begin
      state_d   = ST_STOP;
      tmr_clear = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_d   = ST_WRITE;
            step_d    = '0;
            base_d    = base_from_rd;
            base_en   = 1'b1;
            warn_d    = 1'b0;
            mode_load = 1'b1;
          end
        end
        ST_WRITE: begin
          if (step_q == '0) begin
            step_d = STEP_W'(1);
          end else begin
            state_d  = ST_DWELL;
            tmr_load = 1'b1;
          end
        end
        ST_DWELL: begin
          if (tmr_expire) begin
            if (step_q == STEP_W'(LAST_STEP)) begin
              state_d = ST_CHECK;
            end else begin
              state_d = ST_WRITE;
              step_d  = step_q + STEP_W'(1);
            end
          end
        end
        ST_CHECK: begin
          warn_d  = !(cfg_rd_i[B_DET_A] && cfg_rd_i[B_DET_B]);
          state_d = ST_MODE;
        end
        ST_MODE: begin
          misc_wr = 1'b1;
          state_d = ST_DONE;
        end
        ST_DONE: state_d = ST_IDLE;
        ST_STOP: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      warn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      warn_q  <= warn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  // Outputs
  always_comb begin
    cfg_wr_o    = (state_q == ST_WRITE) || (state_q == ST_STOP);
    cfg_wdata_o = (state_q == ST_STOP) ? (cfg_rd_i | POR_MASK) : step_word;
    busy_o      = (state_q != ST_IDLE) && (state_q != ST_STOP);
    done_o      = (state_q == ST_DONE);
    clk_warn_o  = warn_q;
  end

  // R4: the dwell timer only runs out while the sequencer is dwelling
  p_expire_in_dwell_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    tmr_expire |-> (state_q == ST_DWELL));

  // R3: at most one pulse group per port in any chain write
  p_one_group_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_wr_o && state_q != ST_STOP) |-> ($countones(cfg_wdata_o & (RST_A_MASK | bit_at(B_POR_A))) <= 1));

  // R3: both ports carry the same pulse pattern in every chain write
  p_ports_paired_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_wr_o && state_q != ST_STOP) |->
      ({cfg_wdata_o[B_CTL_A], cfg_wdata_o[B_PLL_A], cfg_wdata_o[B_PHY_A], cfg_wdata_o[B_POR_A]} ==
       {cfg_wdata_o[B_CTL_B], cfg_wdata_o[B_PLL_B], cfg_wdata_o[B_PHY_B], cfg_wdata_o[B_POR_B]}));

  // R7: done never lasts two cycles and is followed by idle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> (!done_o && !busy_o));

  // R8: a start while busy does not end the sequence
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && !done_o && start_i && !stop_i) |=> busy_o);

  // R9: a stop is followed by the power-on-reset write
  p_stop_por_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop_i && state_q != ST_STOP) |=> (cfg_wr_o && (cfg_wdata_o[B_POR_A] && cfg_wdata_o[B_POR_B])));

  // R6: misc writes happen only once the clock check is complete
  p_misc_after_check_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    misc_a_wr_o |-> ($past(state_q) == ST_CHECK));

endmodule

// File: tb/tb_usbphy_bringup_seq.sv
`timescale 1ns/1ps
module tb_usbphy_bringup_seq;

  localparam int DW    = 4;
  localparam int RATIO = 2;
  localparam int NVEC  = 5;
  localparam int LOGN  = 16;

  localparam logic [31:0] CLR = 32'h7F00_0000 | 32'h0000_00E0 | 32'h000E_3800 | 32'h0000_0003;
  localparam logic [31:0] SETB = (32'(RATIO - 1) << 24) | 32'h0000_0100;

  // cfg, misc_a, misc_b, mode_a, mode_b, det_a, det_b
  localparam logic [101:0] VEC [NVEC] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 2'b10, 2'b11, 1'b1, 1'b1},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 2'b00, 2'b10, 1'b1, 1'b1},
    {32'h1234_5678, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 2'b11, 2'b01, 1'b1, 1'b0},
    {32'h8040_0003, 32'h00C0_0000, 32'h0080_0000, 2'b01, 2'b00, 1'b1, 1'b1},
    {32'h7F00_00E0, 32'h0000_0000, 32'hFFFF_FFFF, 2'b11, 2'b11, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, stop_i;
  logic [1:0]  mode_a_i, mode_b_i;
  logic [31:0] cfg_rd_i, misc_a_rd_i, misc_b_rd_i;
  logic        cfg_wr_o, misc_a_wr_o, misc_b_wr_o;
  logic [31:0] cfg_wdata_o, misc_a_wdata_o, misc_b_wdata_o;
  logic        busy_o, done_o, clk_warn_o;

  logic [31:0] cfg_reg, ma_reg, mb_reg;
  logic        det_a, det_b;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_cfg, n_ma, n_mb, n_done, done_cyc, ma_cyc;
  logic [31:0] log_val [LOGN];
  int          log_cyc [LOGN];
  logic [31:0] ma_val, mb_val;

  always #2.5 clk = ~clk;

  assign cfg_rd_i    = {det_a, cfg_reg[30:23], det_b, cfg_reg[21:0]};
  assign misc_a_rd_i = ma_reg;
  assign misc_b_rd_i = mb_reg;

  usbphy_bringup_seq #(
    .DWELL_CYC     (DW),
    .CLK_DIV_RATIO (RATIO)
  ) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .stop_i         (stop_i),
    .mode_a_i       (mode_a_i),
    .mode_b_i       (mode_b_i),
    .cfg_rd_i       (cfg_rd_i),
    .misc_a_rd_i    (misc_a_rd_i),
    .misc_b_rd_i    (misc_b_rd_i),
    .cfg_wr_o       (cfg_wr_o),
    .cfg_wdata_o    (cfg_wdata_o),
    .misc_a_wr_o    (misc_a_wr_o),
    .misc_a_wdata_o (misc_a_wdata_o),
    .misc_b_wr_o    (misc_b_wr_o),
    .misc_b_wdata_o (misc_b_wdata_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .clk_warn_o     (clk_warn_o)
  );

  // Register model
  always @(posedge clk) begin
    if (cfg_wr_o)    cfg_reg <= cfg_wdata_o;
    if (misc_a_wr_o) ma_reg  <= misc_a_wdata_o;
    if (misc_b_wr_o) mb_reg  <= misc_b_wdata_o;
  end

  // Output logger, sampled at the falling edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cfg_wr_o) begin
      if (n_cfg < LOGN) begin
        log_val[n_cfg] = cfg_wdata_o;
        log_cyc[n_cfg] = cyc;
      end
      n_cfg = n_cfg + 1;
    end
    if (misc_a_wr_o) begin ma_val = misc_a_wdata_o; ma_cyc = cyc; n_ma = n_ma + 1; end
    if (misc_b_wr_o) begin mb_val = misc_b_wdata_o; n_mb = n_mb + 1; end
    if (done_o) begin done_cyc = cyc; n_done = n_done + 1; end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_cfg = 0; n_ma = 0; n_mb = 0; n_done = 0; done_cyc = 0; ma_cyc = 0;
  endtask

  function automatic logic [31:0] misc_exp(input logic [31:0] rd, input logic [1:0] m);
    logic [1:0] f;
    f = (m == 2'b10) ? 2'b10 : (m == 2'b11) ? 2'b11 : 2'b00;
    return (rd & ~32'h00C0_0000) | ({30'b0, f} << 22);
  endfunction

  function automatic logic [31:0] grp(input int k);
    case (k)
      1: return 32'h0002_0800;
      3: return 32'h0008_2000;
      5: return 32'h0004_1000;
      7: return 32'h0000_0003;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wait_done();
    for (int t = 0; t < 400; t++) begin
      @(posedge clk);
      if (n_done > 0) break;
    end
    #1;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_vec(input logic [101:0] v, input int vi);
    logic [31:0] rd0, base;
    logic [1:0]  ma_m, mb_m;
    logic        exp_warn;
    @(negedge clk);
    cfg_reg = v[101:70]; ma_reg = v[69:38]; mb_reg = v[37:6];
    ma_m = v[5:4]; mb_m = v[3:2]; det_a = v[1]; det_b = v[0];
    mode_a_i = ma_m; mode_b_i = mb_m;
    clear_logs();
    rd0  = {det_a, cfg_reg[30:23], det_b, cfg_reg[21:0]};
    base = (rd0 & ~CLR) | SETB;
    exp_warn = !(det_a && det_b);
    pulse_start();
    check(busy_o === 1'b1, "R7 busy after start", 32'(busy_o), 1);
    mode_a_i = ~ma_m; mode_b_i = ~mb_m;  // latched at start, later changes unused
    wait_done();
    check(n_cfg == 9, "R3 chain write count", n_cfg, 9);
    check(log_val[0] == base, "R2 first config write", log_val[0], base);
    for (int k = 1; k < 9; k++)
      check(log_val[k] == (base | grp(k)), $sformatf("R3 chain write %0d vec %0d", k, vi), log_val[k], base | grp(k));
    check(log_cyc[1] - log_cyc[0] == 1, "R4 second write adjacent", log_cyc[1] - log_cyc[0], 1);
    for (int k = 2; k < 9; k++)
      check(log_cyc[k] - log_cyc[k-1] == DW + 1, "R4 dwell spacing", log_cyc[k] - log_cyc[k-1], DW + 1);
    check(ma_cyc - log_cyc[8] == DW + 2, "R6 misc write timing", ma_cyc - log_cyc[8], DW + 2);
    check(n_ma == 1 && n_mb == 1, "R6 one misc write per port", n_ma + n_mb, 2);
    check(ma_val == misc_exp(v[69:38], ma_m), "R6 port A misc", ma_val, misc_exp(v[69:38], ma_m));
    check(mb_val == misc_exp(v[37:6], mb_m), "R6 port B misc", mb_val, misc_exp(v[37:6], mb_m));
    check(clk_warn_o == exp_warn, "R5 clock warning", 32'(clk_warn_o), 32'(exp_warn));
    check(n_done == 1 && done_cyc == ma_cyc + 1, "R7 done pulse", done_cyc, ma_cyc + 1);
    check(busy_o == 1'b0, "R7 busy cleared", 32'(busy_o), 0);
  endtask

  initial begin
    logic [31:0] exp_w;
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    mode_a_i = 2'b00; mode_b_i = 2'b00;
    cfg_reg = '0; ma_reg = '0; mb_reg = '0; det_a = 1'b1; det_b = 1'b1;
    clear_logs();
    repeat (4) @(negedge clk);
    // R1: reset state during reset
    check({busy_o, done_o, clk_warn_o, cfg_wr_o, misc_a_wr_o, misc_b_wr_o} == 6'b0,
          "R1 outputs in reset", {26'b0, busy_o, done_o, clk_warn_o, cfg_wr_o, misc_a_wr_o, misc_b_wr_o}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check({busy_o, done_o, clk_warn_o, cfg_wr_o, misc_a_wr_o, misc_b_wr_o} == 6'b0 && n_cfg == 0,
          "R1 outputs after reset", {26'b0, busy_o, done_o, clk_warn_o, cfg_wr_o, misc_a_wr_o, misc_b_wr_o}, 0);

    // Vector table
    for (int vi = 0; vi < NVEC; vi++) run_vec(VEC[vi], vi);

    // R8: start while busy
    @(negedge clk);
    cfg_reg = 32'h0F0F_0F0F; det_a = 1'b1; det_b = 1'b1;
    clear_logs();
    pulse_start();
    for (int t = 0; t < 100; t++) begin @(posedge clk); if (n_cfg >= 3) break; end
    pulse_start();
    wait_done();
    repeat (12) @(negedge clk);
    check(n_cfg == 9, "R8 no extra writes", n_cfg, 9);
    check(n_done == 1, "R8 single done", n_done, 1);
    check(log_cyc[3] - log_cyc[2] == DW + 1, "R8 timing undisturbed", log_cyc[3] - log_cyc[2], DW + 1);

    // R9: stop during a dwell
    clear_logs();
    pulse_start();
    for (int t = 0; t < 100; t++) begin @(posedge clk); if (n_cfg >= 4) break; end
    @(negedge clk);
    exp_w = cfg_rd_i | 32'h3;
    stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
    @(posedge clk); #1;
    check(n_cfg == 5 && log_val[4] == exp_w, "R9 abort write", log_val[4], exp_w);
    check(busy_o == 1'b0, "R9 idle after abort", 32'(busy_o), 0);
    repeat (40) @(negedge clk);
    check(n_done == 0 && n_cfg == 5, "R9 no done after abort", n_done, 0);

    // R9: stop while idle, and stop beating start
    @(negedge clk);
    cfg_reg = 32'h1234_5678; det_a = 1'b0; det_b = 1'b1;
    clear_logs();
    exp_w = {1'b0, cfg_reg[30:23], 1'b1, cfg_reg[21:0]} | 32'h3;
    stop_i = 1'b1; start_i = 1'b1;
    @(negedge clk) begin stop_i = 1'b0; start_i = 1'b0; end
    @(posedge clk); #1;
    check(n_cfg == 1 && log_val[0] == exp_w, "R9 idle stop write keeps bits", log_val[0], exp_w);
    repeat (30) @(negedge clk);
    check(n_cfg == 1 && n_done == 0 && busy_o == 1'b0, "R9 stop wins over start", n_cfg, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule